// File: doc/BRIEF.md
# DAC Self-Calibration Sequencer

This block is the digital controller behind a self-calibrating precision DAC. A falling edge on the active-low calibrate input, or a power-up or supply-fault event, puts the converter into the uncalibrated condition. While calibration runs, the block drives the main DAC code itself instead of the user word. It also steers the analog output multiplexer to an external hold level, so the load never sees the calibration activity.

A calibration pass has two parts. First it nulls the offset at unipolar zero or at bipolar midscale, as the range input selects. Then it walks the 63 carry boundaries between adjacent segments of the upper six code bits. At each boundary it measures the level one extra LSB above the code just below the boundary, and captures that level on a transfer-standard DAC. It then steps the main code up by one and trims a correction DAC until the output matches the captured level. The correction is written into a 64-entry table, one entry per top-six-bit segment.

In normal operation the top six bits of the active code address that table, and the entry drives the correction DAC. The comparator is modelled as a single digital input. Every null is a most-significant-bit-first successive-approximation search.

Top module: `dac_cal_seq`

## Requirements
- R1: A 1-to-0 transition of `cal_n_i` sampled on a clock edge, with `por_fault_i` low, starts calibration. By the second edge after it, `mux_sel_dac_o` (1 = DAC output, 0 = hold input) and `ready_o` are both 0.
- R2: Offset step. The main code is 0 when `bipolar_i` is 0 and midscale (MSB only set) when it is 1, with the extra LSB off and the correction code at 0. The transfer code holds the ideal level, which is the main code shifted left by XFER_W-CODE_W. The offset trim is nulled against that level.
- R3: Each null is a successive-approximation search from the MSB down. Each trial bit is held for NULL_WAIT settle cycles, and it is kept only if `cmp_i` is low (`cmp_i` high means the reference exceeds the output). The result is the largest code that keeps `cmp_i` low.
- R4: For boundary k (1..63) the main code is (k·2^(CODE_W-6))−1 with `extra_lsb_o` high. During this step the correction code shows the stored entry for segment k−1, and the transfer code is nulled.
- R5: Next, `extra_lsb_o` falls and the main code rises by exactly one, while the transfer code is held. The correction code is nulled and written to table entry k. Entry 0 is written as 0.
- R6: Outside calibration, `main_code_o` follows `user_code_i` one cycle later. In that same cycle `corr_code_o` shows the table entry addressed by the top six bits of that code.
- R7: After boundary 63 the main code is reloaded from `user_code_i`. `ready_o` and `mux_sel_dac_o` then rise together, exactly `settle_cycles_i`+2 cycles after the reload.
- R8: `por_fault_i` high forces the uncalibrated state: mux 0, ready 0, correction 0. It overrides a calibrate strobe, and the state persists after the fault clears until a new strobe.
- R9: While `hbe_n_i` is low, `ready_o` (one cycle later) is 1 exactly when calibration is in progress. It is 0 when calibrated, and 0 when uncalibrated after a fault.
- R10: A calibrate strobe during a running calibration restarts at the offset step, and the new run completes with a correct table.
- R11: After reset the block is uncalibrated, with `ready_o`, `mux_sel_dac_o` and `corr_code_o` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| user_code_i | input | CODE_W | First-rank register contents |
| bipolar_i | input | 1 | 1 = bipolar range, offset nulled at midscale |
| cal_n_i | input | 1 | Calibrate strobe, active low |
| hbe_n_i | input | 1 | Low = status query on the ready flag |
| por_fault_i | input | 1 | Power-up or supply fault event |
| settle_cycles_i | input | SETTLE_W | Output settle wait after the final reload |
| cmp_i | input | 1 | Comparator: 1 = reference above output |
| main_code_o | output | CODE_W | Main DAC code |
| extra_lsb_o | output | 1 | Extra calibration LSB enable |
| xfer_code_o | output | XFER_W | Transfer-standard DAC code |
| corr_code_o | output | CORR_W | Correction DAC code (subtractive) |
| offset_trim_o | output | CORR_W | Offset trim DAC code (subtractive) |
| mux_sel_dac_o | output | 1 | Output multiplexer: 1 = DAC, 0 = hold input |
| ready_o | output | 1 | Calibration-good flag / status reply |

## Verification
The bench models the converter with a distinct carry error per segment and a fixed offset. Full passes are run in both unipolar and bipolar range, so the bench can see which reference code the offset step nulls at. It also confirms that the stored corrections are independent of that choice. Table lookups use codes on both sides of segment boundaries, including the all-zero and all-one codes, so an off-by-one in the boundary codes or in the table address stands out. Two settle counts separate the final handoff delay from the rest of the pass. The fault and restart scenarios show that the uncalibrated state is sticky and that a second strobe really starts over.

// File: rtl/dac_cal_pkg.sv
package dac_cal_pkg;
  typedef enum logic [2:0] {
    ST_UNCAL,
    ST_READY,
    ST_OFFSET,
    ST_XFER,
    ST_CORR,
    ST_SETTLE
  } cal_state_t;
endpackage

// File: rtl/dac_cal_sar.sv
// Successive-approximation null engine: MSB first, each trial bit held for
// WAIT_CYC cycles, bit kept while the comparator reads low.
module dac_cal_sar #(
  parameter int W        = 8,
  parameter int WAIT_CYC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         cmp_i,
  output logic [W-1:0] code_o,
  output logic         done_o
);
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1;
  localparam int CNT_W = $clog2(WAIT_CYC + 1) + 1;

  logic [W-1:0]     code_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        code_q <= {1'b1, {(W-1){1'b0}}};
        idx_q  <= IDX_W'(W - 1);
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (cnt_q != CNT_W'(WAIT_CYC)) begin
          cnt_q <= cnt_q + 1'b1;
        end else begin
          cnt_q <= '0;
          if (cmp_i) code_q[idx_q] <= 1'b0;
          if (idx_q == '0) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            code_q[idx_q - 1'b1] <= 1'b1;
            idx_q <= idx_q - 1'b1;
          end
        end
      end
    end
  end

  assign code_o = code_q;
  assign done_o = done_q;
endmodule

// File: rtl/dac_cal_ram.sv
// Correction table: one synchronous write port, one registered read port.
module dac_cal_ram #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/dac_cal_seq.sv
module dac_cal_seq #(
  parameter int CODE_W    = 16,
  parameter int SEG_W     = 6,
  parameter int XFER_W    = 20,
  parameter int CORR_W    = 8,
  parameter int NULL_WAIT = 2,
  parameter int SETTLE_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CODE_W-1:0]   user_code_i,
  input  logic                bipolar_i,
  input  logic                cal_n_i,
  input  logic                hbe_n_i,
  input  logic                por_fault_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  input  logic                cmp_i,
  output logic [CODE_W-1:0]   main_code_o,
  output logic                extra_lsb_o,
  output logic [XFER_W-1:0]   xfer_code_o,
  output logic [CORR_W-1:0]   corr_code_o,
  output logic [CORR_W-1:0]   offset_trim_o,
  output logic                mux_sel_dac_o,
  output logic                ready_o
);
  import dac_cal_pkg::*;

  localparam int LOW_W = CODE_W - SEG_W;
  localparam int SHIFT = XFER_W - CODE_W;
  localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

  cal_state_t          state_q;
  logic [CODE_W-1:0]   main_q;
  logic                extra_q;
  logic [CORR_W-1:0]   trim_q;
  logic [CORR_W-1:0]   prev_corr_q;
  logic [SEG_W-1:0]    seg_q;
  logic [SETTLE_W-1:0] settle_q;
  logic                xfer_start_q;
  logic                corr_start_q;
  logic                cal_n_q;
  logic                ready_q;
  logic                mux_q;

  logic [XFER_W-1:0]   xfer_sar_code;
  logic                xfer_done;
  logic [CORR_W-1:0]   corr_sar_code;
  logic                corr_done;
  logic [CORR_W-1:0]   ram_rdata;
  logic                ram_we;
  logic [SEG_W-1:0]    ram_waddr;
  logic [CORR_W-1:0]   ram_wdata;
  logic                strobe;
  logic                in_cal;

  assign strobe = cal_n_q & ~cal_n_i;
  assign in_cal = (state_q == ST_OFFSET) || (state_q == ST_XFER) ||
                  (state_q == ST_CORR)   || (state_q == ST_SETTLE);

  dac_cal_sar #(.W(XFER_W), .WAIT_CYC(NULL_WAIT)) u_xfer_sar (
    .clk(clk), .rst(rst), .start_i(xfer_start_q), .cmp_i(cmp_i),
    .code_o(xfer_sar_code), .done_o(xfer_done)
  );

  dac_cal_sar #(.W(CORR_W), .WAIT_CYC(NULL_WAIT)) u_corr_sar (
    .clk(clk), .rst(rst), .start_i(corr_start_q), .cmp_i(cmp_i),
    .code_o(corr_sar_code), .done_o(corr_done)
  );

  always_comb begin
    ram_we    = corr_done && !por_fault_i && !strobe &&
                ((state_q == ST_OFFSET) || (state_q == ST_CORR));
    ram_waddr = (state_q == ST_OFFSET) ? '0 : seg_q;
    ram_wdata = (state_q == ST_OFFSET) ? '0 : corr_sar_code;
  end

  dac_cal_ram #(.AW(SEG_W), .DW(CORR_W)) u_ram (
    .clk(clk), .we_i(ram_we), .waddr_i(ram_waddr), .wdata_i(ram_wdata),
    .raddr_i(user_code_i[CODE_W-1 -: SEG_W]), .rdata_o(ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_UNCAL;
      main_q       <= '0;
      extra_q      <= 1'b0;
      trim_q       <= '0;
      prev_corr_q  <= '0;
      seg_q        <= '0;
      settle_q     <= '0;
      xfer_start_q <= 1'b0;
      corr_start_q <= 1'b0;
      cal_n_q      <= 1'b1;
      ready_q      <= 1'b0;
      mux_q        <= 1'b0;
    end else begin
      cal_n_q      <= cal_n_i;
      xfer_start_q <= 1'b0;
      corr_start_q <= 1'b0;
      ready_q      <= hbe_n_i ? (state_q == ST_READY) : in_cal;
      mux_q        <= (state_q == ST_READY);
      if (por_fault_i) begin
        state_q <= ST_UNCAL;
        extra_q <= 1'b0;
        main_q  <= user_code_i;
      end else if (strobe) begin
        state_q      <= ST_OFFSET;
        main_q       <= bipolar_i ? MID_CODE : '0;
        extra_q      <= 1'b0;
        corr_start_q <= 1'b1;
      end else begin
        unique case (state_q)
          ST_OFFSET: if (corr_done) begin
            trim_q       <= corr_sar_code;
            prev_corr_q  <= '0;
            seg_q        <= SEG_W'(1);
            main_q       <= {{SEG_W{1'b0}}, {LOW_W{1'b1}}};
            extra_q      <= 1'b1;
            xfer_start_q <= 1'b1;
            state_q      <= ST_XFER;
          end
          ST_XFER: if (xfer_done) begin
            extra_q      <= 1'b0;
            main_q       <= main_q + 1'b1;
            corr_start_q <= 1'b1;
            state_q      <= ST_CORR;
          end
          ST_CORR: if (corr_done) begin
            prev_corr_q <= corr_sar_code;
            if (seg_q == '1) begin
              main_q   <= user_code_i;
              settle_q <= '0;
              state_q  <= ST_SETTLE;
            end else begin
              seg_q        <= seg_q + 1'b1;
              main_q       <= {seg_q, {LOW_W{1'b1}}};
              extra_q      <= 1'b1;
              xfer_start_q <= 1'b1;
              state_q      <= ST_XFER;
            end
          end
          ST_SETTLE: begin
            main_q <= user_code_i;
            if (settle_q >= settle_cycles_i) state_q <= ST_READY;
            else settle_q <= settle_q + 1'b1;
          end
          default: main_q <= user_code_i;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_OFFSET:           corr_code_o = '0;
      ST_XFER:             corr_code_o = prev_corr_q;
      ST_CORR:             corr_code_o = corr_sar_code;
      ST_READY, ST_SETTLE: corr_code_o = ram_rdata;
      default:             corr_code_o = '0;
    endcase
  end

  assign xfer_code_o   = (state_q == ST_OFFSET) ? (XFER_W'(main_q) << SHIFT) : xfer_sar_code;
  assign offset_trim_o = (state_q == ST_OFFSET) ? corr_sar_code : trim_q;
  assign main_code_o   = main_q;
  assign extra_lsb_o   = extra_q;
  assign mux_sel_dac_o = mux_q;
  assign ready_o       = ready_q;
endmodule

// File: rtl/dac_cal_seq_chk.sv
module dac_cal_seq_chk #(
  parameter int CODE_W = 16,
  parameter int SEG_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              cal_n_i,
  input logic              por_fault_i,
  input logic [CODE_W-1:0] main_code_o,
  input logic              extra_lsb_o,
  input logic              mux_sel_dac_o,
  input logic              ready_o
);
  localparam int LOW_W = CODE_W - SEG_W;

  // R8: a fault takes the output away from the DAC and drops the flag
  assert_fault_mux_R8: assert property (@(posedge clk) disable iff (rst)
    por_fault_i |-> ##2 (!mux_sel_dac_o && !ready_o));

  // R1: a calibrate strobe switches the output to the hold input
  assert_strobe_hold_R1: assert property (@(posedge clk) disable iff (rst)
    ($fell(cal_n_i) && !por_fault_i) |-> ##2 !mux_sel_dac_o);

  // R4: the extra LSB is only used one code below a segment boundary
  assert_extra_below_R4: assert property (@(posedge clk) disable iff (rst)
    extra_lsb_o |-> (main_code_o[LOW_W-1:0] == {LOW_W{1'b1}}));

  // R5: dropping the extra LSB steps the main code up by one
  assert_step_up_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(extra_lsb_o) && !$past(por_fault_i) &&
     !($past(cal_n_i, 2) && !$past(cal_n_i)))
    |-> (main_code_o == CODE_W'($past(main_code_o) + 1'b1)));

  // R7: the DAC output is never presented while the sequencer drives the extra LSB
  assert_mux_idle_R7: assert property (@(posedge clk) disable iff (rst)
    mux_sel_dac_o |-> !extra_lsb_o);
endmodule

bind dac_cal_seq dac_cal_seq_chk #(.CODE_W(CODE_W), .SEG_W(SEG_W)) u_chk (
  .clk(clk), .rst(rst), .cal_n_i(cal_n_i), .por_fault_i(por_fault_i),
  .main_code_o(main_code_o), .extra_lsb_o(extra_lsb_o),
  .mux_sel_dac_o(mux_sel_dac_o), .ready_o(ready_o)
);

// File: tb/dac_cal_seq_bench.sv
module dac_cal_seq_bench;
  localparam int CODE_W = 16, SEG_W = 6, XFER_W = 20, CORR_W = 8;
  localparam int NULL_WAIT = 2, SETTLE_W = 8;
  localparam int OFF_ERR = 37;
  localparam int LOW_W = CODE_W - SEG_W;

  logic clk = 1'b0, rst = 1'b1;
  logic [CODE_W-1:0] user_code = 16'h1234;
  logic bipolar = 1'b0, cal_n = 1'b1, hbe_n = 1'b1, por_fault = 1'b0;
  logic [SETTLE_W-1:0] settle = 8'd5;
  logic cmp;
  logic [CODE_W-1:0] main_code;
  logic extra;
  logic [XFER_W-1:0] xfer_code;
  logic [CORR_W-1:0] corr_code, trim_code;
  logic mux_dac, ready;

  always #4 clk = ~clk;

  dac_cal_seq #(.CODE_W(CODE_W), .SEG_W(SEG_W), .XFER_W(XFER_W), .CORR_W(CORR_W),
                .NULL_WAIT(NULL_WAIT), .SETTLE_W(SETTLE_W)) u_dac_cal_seq (
    .clk(clk), .rst(rst), .user_code_i(user_code), .bipolar_i(bipolar),
    .cal_n_i(cal_n), .hbe_n_i(hbe_n), .por_fault_i(por_fault),
    .settle_cycles_i(settle), .cmp_i(cmp), .main_code_o(main_code),
    .extra_lsb_o(extra), .xfer_code_o(xfer_code), .corr_code_o(corr_code),
    .offset_trim_o(trim_code), .mux_sel_dac_o(mux_dac), .ready_o(ready)
  );

  function automatic int seg_err(int k);
    return (k * 53) % 211;
  endfunction

  // converter model, output in 1/16 LSB units; correction and trim subtract
  always_comb begin
    int vout;
    vout = int'(main_code) * 16 + (extra ? 16 : 0) + seg_err(int'(main_code) >> LOW_W)
         + OFF_ERR - int'(corr_code) - int'(trim_code);
    cmp = int'(xfer_code) > vout;
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // boundary monitor
  bit mon_en = 1'b0;
  int a_samp, a_err, falls, x_err, inc_err;
  bit prev_extra;
  int prev_main, prev_corr;

  always @(negedge clk) begin
    if (mon_en) begin
      if (extra) begin
        a_samp++;
        if (main_code[LOW_W-1:0] != {LOW_W{1'b1}} ||
            int'(corr_code) != seg_err(int'(main_code) >> LOW_W)) a_err++;
      end
      if (prev_extra && !extra) begin
        int exp_x;
        falls++;
        exp_x = prev_main * 16 + 16 + seg_err(prev_main >> LOW_W) + OFF_ERR
              - prev_corr - int'(trim_code);
        if (int'(xfer_code) != exp_x) x_err++;
        if (int'(main_code) != prev_main + 1) inc_err++;
      end
      prev_extra = extra;
      prev_main  = int'(main_code);
      prev_corr  = int'(corr_code);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_cal();
    cal_n = 1'b0;
    tick(1);
    cal_n = 1'b1;
  endtask

  task automatic wait_ready(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (ready) begin ok = 1'b1; break; end
      tick(1);
    end
  endtask

  task automatic test_reset();
    check(!ready, "R11", "ready after reset", ready, 0);
    check(!mux_dac, "R11", "mux after reset", mux_dac, 0);
    check(corr_code == 0, "R11", "corr after reset", corr_code, 0);
  endtask

  task automatic test_full_cal(bit bip, int settle_val);
    bit seen;
    int cnt;
    bipolar = bip;
    settle = SETTLE_W'(settle_val);
    user_code = 16'h1234;
    a_samp = 0; a_err = 0; falls = 0; x_err = 0; inc_err = 0;
    prev_extra = 1'b0;
    mon_en = 1'b1;
    strobe_cal();
    tick(1);
    check(!mux_dac, "R1", "mux after strobe", mux_dac, 0);
    check(!ready, "R1", "ready after strobe", ready, 0);
    check(int'(main_code) == (bip ? 32768 : 0), "R2", "offset code", main_code, bip ? 32768 : 0);
    check(int'(xfer_code) == (bip ? 32768 * 16 : 0), "R2", "offset reference", xfer_code, bip ? 32768 * 16 : 0);
    seen = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (main_code == user_code && !extra) begin seen = 1'b1; break; end
      tick(1);
    end
    check(seen, "R7", "reload seen", seen, 1);
    cnt = 0;
    while (!ready && cnt < 1000) begin tick(1); cnt++; end
    check(cnt == settle_val + 2, "R7", "reload to ready cycles", cnt, settle_val + 2);
    check(mux_dac, "R7", "mux with ready", mux_dac, 1);
    mon_en = 1'b0;
    check(int'(trim_code) == OFF_ERR + (bip ? seg_err(32) : 0), "R2", "offset trim",
          trim_code, OFF_ERR + (bip ? seg_err(32) : 0));
    check(falls == 63, "R4", "boundaries walked", falls, 63);
    check(a_samp > 0 && a_err == 0, "R4", "below-boundary step errors", a_err, 0);
    check(x_err == 0, "R3", "transfer null errors", x_err, 0);
    check(inc_err == 0, "R5", "step-up errors", inc_err, 0);
  endtask

  task automatic test_lookup(string req);
    int codes [7] = '{0, 16'h03FF, 16'h0400, 16'h8000, 16'hFC00, 16'hFFFF, 16'h5A5A};
    foreach (codes[i]) begin
      user_code = CODE_W'(codes[i]);
      tick(1);
      check(int'(main_code) == codes[i], "R6", "main follows user", main_code, codes[i]);
      check(int'(corr_code) == seg_err(codes[i] >> LOW_W), req, "table entry",
            corr_code, seg_err(codes[i] >> LOW_W));
    end
  endtask

  task automatic test_query();
    bit ok;
    user_code = 16'h1234;
    strobe_cal();
    tick(50);
    hbe_n = 1'b0;
    tick(2);
    check(ready, "R9", "query during calibration", ready, 1);
    check(!mux_dac, "R9", "mux during query", mux_dac, 0);
    hbe_n = 1'b1;
    tick(2);
    check(!ready, "R9", "flag after query", ready, 0);
    wait_ready(ok);
    check(ok, "R9", "calibration completes", ok, 1);
    hbe_n = 1'b0;
    tick(2);
    check(!ready, "R9", "query when calibrated", ready, 0);
    hbe_n = 1'b1;
    tick(2);
    check(ready, "R9", "flag back after query", ready, 1);
  endtask

  task automatic test_fault();
    bit ok;
    user_code = 16'h4321;
    por_fault = 1'b1;
    tick(1);
    cal_n = 1'b0;
    tick(1);
    cal_n = 1'b1;
    tick(1);
    check(!mux_dac, "R8", "mux under fault", mux_dac, 0);
    check(!ready, "R8", "ready under fault", ready, 0);
    check(corr_code == 0, "R8", "corr under fault", corr_code, 0);
    check(main_code == 16'h4321, "R8", "strobe ignored under fault", main_code, 16'h4321);
    por_fault = 1'b0;
    tick(3);
    check(!mux_dac && !ready, "R8", "stays uncalibrated", {mux_dac, ready}, 0);
    hbe_n = 1'b0;
    tick(2);
    check(!ready, "R9", "query after fault", ready, 0);
    hbe_n = 1'b1;
    strobe_cal();
    wait_ready(ok);
    check(ok, "R8", "recalibrates after fault", ok, 1);
  endtask

  task automatic test_restart();
    bit ok;
    bipolar = 1'b0;
    user_code = 16'h1234;
    strobe_cal();
    tick(400);
    strobe_cal();
    check(main_code == 0 && !extra, "R10", "restart at offset code", main_code, 0);
    tick(1);
    check(!mux_dac, "R10", "mux held on restart", mux_dac, 0);
    wait_ready(ok);
    check(ok, "R10", "restarted run completes", ok, 1);
    check(int'(trim_code) == OFF_ERR, "R10", "trim after restart", trim_code, OFF_ERR);
    test_lookup("R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(2);
    test_reset();
    test_full_cal(1'b0, 5);
    test_lookup("R5");
    test_full_cal(1'b1, 17);
    test_lookup("R6");
    test_query();
    test_fault();
    test_restart();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule